// File: doc/BRIEF.md
# Multi-Master Open-Drain Serial Bit Engine

This block moves one data bit at a time across a two-wire open-drain serial bus (a clock line and a data line) that other masters and slow slaves may share. It never drives a line high. It only pulls a line low or lets it go, and it reads both wired-AND lines back through synchronizers. The clock it produces is not free-running. A low phase is timed only while the clock line is seen low. A high phase is timed only after the clock line is seen high. A clock line that falls early, because another master pulled it, ends the high phase at once.

A controller above this block issues one command per bit: send a bit, receive a bit, or let go of the bus. The command port is valid/ready. A command waits, with `cmd_ready` low, until the engine is idle and it either holds the bus from its previous bit or sees both lines high. Each accepted command ends with a single-cycle `rsp_valid` pulse carrying the bit read from the data line and the arbitration-lost flag. The response has no back-pressure, so the controller must take it in the cycle it is offered. When a sent one reads back as a zero, the engine lets go of both lines straight away, stays busy until the bit slot would have ended, and then reports the loss.

Top module: `mmbe_bit_engine`

## Requirements
- R1: The outputs `scl_oe`/`sda_oe` are pull-low enables (1 = pull low, 0 = release). After reset both are 0, `busy` is 0, `rsp_valid` is 0 and, with both lines high, `cmd_ready` is 1.
- R2: A send or receive command (`cmd_op` 2'b01 = send, 2'b10 = receive) is accepted only while the engine is idle and either holds the bus from its previous bit or samples both lines high. Otherwise `cmd_ready` stays 0 and the lines are left untouched.
- R3: Each send or receive produces exactly one rising edge on the clock line. During a send, the data line at that edge equals `cmd_bit`.
- R4: While a bit is in progress, `sda_oe` changes only while the clock line is sampled low.
- R5: The low phase lasts at least `half_period` cycles of the clock line sampled low, and no more than `half_period`+4 cycles when no other device holds the clock line.
- R6: After releasing the clock line, the engine waits for as long as another device holds it low. Its high-phase timing starts only once the line is sampled high, so the high phase is at least `half_period` cycles even after stretching.
- R7: Without interference, the high phase lasts from `half_period` to `half_period`+5 cycles. If the clock line falls early, the engine pulls it low again within 4 cycles and ends the bit.
- R8: During a receive, `rsp_bit` is the data-line level sampled in the high phase.
- R9: When a sent one reads back low during the high phase, the engine releases both lines at once. It stays busy until the slot ends, then reports `rsp_lost`=1 and no longer holds the bus.
- R10: A release command (`cmd_op` 2'b00 or 2'b11) frees both lines and answers with `rsp_valid` one cycle later, with no slot timing.
- R11: `rsp_valid` is a single-cycle pulse issued in the first cycle that `busy` is low after a bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | CNT_W | Clock half-period in cycles (values below 2 are treated as 2) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_op | input | 2 | 01 send, 10 receive, 00/11 release bus |
| cmd_bit | input | 1 | Bit to send |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_bit | output | 1 | Data-line level sampled for the bit |
| rsp_lost | output | 1 | Arbitration was lost in this bit |
| busy | output | 1 | A bit slot is in progress |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |

## Verification
The assertions check on every cycle the properties that hold no matter what the other bus agents do. The data output never moves while the clock line is high mid-bit. No bit starts on a bus that is neither held nor free. A lost bit always leaves both lines released and the bus unowned. The response is a single pulse at the fall of `busy`. Only the bench scenarios can show the timing behaviour, because it depends on what other agents do to the lines: the phase lengths, waiting out a stretching slave, cutting a high phase short when another master pulls the clock, the read-back value, and blocking a start on a busy bus.

// File: rtl/mmbe_pkg.sv
package mmbe_pkg;

  typedef enum logic [1:0] {
    OP_FREE  = 2'b00,
    OP_SEND  = 2'b01,
    OP_RECV  = 2'b10,
    OP_FREE2 = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_RISE = 3'd2,
    ST_HIGH = 3'd3
  } slot_e;

endpackage

// File: rtl/mmbe_line_sync.sv
module mmbe_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // idle bus reads high, so every stage resets to one
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mmbe_phase_timer.sv
module mmbe_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          at_mid,
  output logic          at_end
);
  localparam logic [CW-1:0] MIN_LIM = CW'(2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_eff;

  assign lim_eff = (limit < MIN_LIM) ? MIN_LIM : limit;
  assign at_end  = run && (cnt_q >= lim_eff - CW'(1));
  assign at_mid  = run && (cnt_q == (lim_eff >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (clear)                            cnt_q <= '0;
    else if (run && cnt_q != {CW{1'b1}})       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/mmbe_bit_engine.sv
module mmbe_bit_engine #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             rsp_valid,
  output logic             rsp_bit,
  output logic             rsp_lost,
  output logic             busy,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  import mmbe_pkg::*;

  slot_e st_q;
  logic  scl_drv_q, sda_drv_q;
  logic  bit_q, is_send_q, own_q, lost_q, sampled_q, sda_set_q;
  logic  rsp_valid_q, rsp_bit_q, rsp_lost_q;
  logic  scl_s, sda_s;
  logic  t_clear, t_run, t_mid, t_end;
  logic  accept, is_bit_op;
  logic  lose_now;

  mmbe_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  mmbe_phase_timer #(.CW(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (t_clear),
    .run    (t_run),
    .limit  (half_period),
    .at_mid (t_mid),
    .at_end (t_end)
  );

  assign cmd_ready = (st_q == ST_IDLE) && (own_q || (scl_s && sda_s));
  assign accept    = cmd_valid && cmd_ready;
  assign is_bit_op = (cmd_op == OP_SEND) || (cmd_op == OP_RECV);
  assign lose_now  = is_send_q && bit_q && !sda_s && !lost_q;

  // timer runs only while the observed line is in the phase being timed
  always_comb begin
    t_clear = 1'b0;
    t_run   = 1'b0;
    unique case (st_q)
      ST_IDLE: t_clear = 1'b1;
      ST_LOW:  t_run   = !scl_s;
      ST_RISE: t_clear = 1'b1;
      ST_HIGH: t_run   = scl_s;
      default: t_clear = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      scl_drv_q   <= 1'b0;
      sda_drv_q   <= 1'b0;
      bit_q       <= 1'b0;
      is_send_q   <= 1'b0;
      own_q       <= 1'b0;
      lost_q      <= 1'b0;
      sampled_q   <= 1'b0;
      sda_set_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_bit_q   <= 1'b0;
      rsp_lost_q  <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_bit_op) begin
              st_q      <= ST_LOW;
              scl_drv_q <= 1'b1;
              bit_q     <= cmd_bit;
              is_send_q <= (cmd_op == OP_SEND);
              lost_q    <= 1'b0;
              sampled_q <= 1'b0;
              sda_set_q <= 1'b0;
            end else begin
              scl_drv_q   <= 1'b0;
              sda_drv_q   <= 1'b0;
              own_q       <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_bit_q   <= sda_s;
              rsp_lost_q  <= 1'b0;
            end
          end
        end
        ST_LOW: begin
          if (!scl_s && !sda_set_q) begin
            sda_drv_q <= is_send_q && !bit_q;
            sda_set_q <= 1'b1;
          end
          if (t_end && sda_set_q) begin
            st_q      <= ST_RISE;
            scl_drv_q <= 1'b0;
          end
        end
        ST_RISE: begin
          if (scl_s) st_q <= ST_HIGH;
        end
        ST_HIGH: begin
          if (lose_now) begin
            lost_q    <= 1'b1;
            scl_drv_q <= 1'b0;
            sda_drv_q <= 1'b0;
          end
          if (t_mid && !sampled_q) begin
            rsp_bit_q <= sda_s;
            sampled_q <= 1'b1;
          end
          if (!scl_s || t_end) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_lost_q  <= lost_q || lose_now;
            if (!sampled_q) rsp_bit_q <= sda_s;
            if (lost_q || lose_now) begin
              own_q     <= 1'b0;
              scl_drv_q <= 1'b0;
              sda_drv_q <= 1'b0;
            end else begin
              own_q     <= 1'b1;
              scl_drv_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_bit   = rsp_bit_q;
  assign rsp_lost  = rsp_lost_q;
  assign scl_oe    = scl_drv_q;
  assign sda_oe    = sda_drv_q;
endmodule

// File: rtl/mmbe_checker.sv
module mmbe_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_lost,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_s,
  input logic sda_s,
  input logic own_q
);
  // R4: data output moves mid-bit only while the clock line reads low
  a_r4_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sda_oe)) |-> !scl_s);

  // R2: a start without holding the bus needs a free bus
  a_r2_start_on_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !own_q) |-> (scl_s && sda_s));

  // R9: a lost bit leaves both lines released
  a_r9_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_lost) |-> (!scl_oe && !sda_oe));

  // R9: a lost bit gives up ownership
  a_r9_lost_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_lost) |-> !own_q);

  // R11: response is one cycle wide
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11: every slot end produces a response
  a_r11_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
endmodule

bind mmbe_bit_engine mmbe_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_lost  (rsp_lost),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .scl_s     (scl_s),
  .sda_s     (sda_s),
  .own_q     (own_q)
);

// File: tb/mmbe_bit_engine_bench.sv
module mmbe_bit_engine_bench;
  localparam int CNT_W = 8;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] half_period = CNT_W'(HALF);
  logic cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_ready, rsp_valid, rsp_bit, rsp_lost, busy, scl_oe, sda_oe;
  logic oth_scl = 1'b0, oth_sda = 1'b0;  // other agents pulling low
  wire  scl_line = !scl_oe && !oth_scl;
  wire  sda_line = !sda_oe && !oth_sda;

  int checks = 0, failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mmbe_bit_engine #(.CNT_W(CNT_W)) u_mmbe_bit_engine (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_valid(rsp_valid), .rsp_bit(rsp_bit), .rsp_lost(rsp_lost), .busy(busy),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference monitor, evaluated every clock away from the active edge
  int  rises = 0, low_len = 0, high_len = 0, last_low = 0, last_high = 0;
  int  sda_at_rise = 0, fall_cyc = 0, pull_cyc = 0;
  logic p_scl = 1'b1, p_sda_oe = 1'b0, p_busy = 1'b0, p_scl_oe = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && p_busy && sda_oe != p_sda_oe) begin
        chk(!scl_line, "R4 sda moved with scl high", 1, 0);
      end
      if (scl_line && !p_scl) begin
        if (busy) rises++;
        sda_at_rise = sda_line;
        last_low = low_len;
      end
      if (!scl_line && p_scl) begin
        last_high = high_len;
        fall_cyc = cyc;
      end
      if (scl_oe && !p_scl_oe) pull_cyc = cyc;
      if (scl_line) begin high_len = scl_line == p_scl ? high_len + 1 : 1; end
      else          begin low_len  = scl_line == p_scl ? low_len + 1 : 1; end
    end
    p_scl = scl_line; p_sda_oe = sda_oe; p_busy = busy; p_scl_oe = scl_oe;
  end

  logic got_bit, got_lost;
  task automatic do_cmd(input logic [1:0] op, input logic b);
    int guard = 0;
    @(negedge clk);
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    while (!cmd_ready && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid && guard < 4000) begin @(negedge clk); guard++; end
    got_bit = rsp_bit; got_lost = rsp_lost;
    chk(rsp_valid == 1'b1, "R11 response seen", rsp_valid, 1);
    chk(busy == 1'b0, "R11 busy low with response", busy, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 pulse width one", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int r0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && rsp_valid == 0, "R1 idle", {busy, rsp_valid}, 0);
    chk(cmd_ready == 1, "R1 ready on free bus", cmd_ready, 1);

    // R2 start blocked while another agent holds the data line
    oth_sda = 1'b1;
    repeat (4) @(negedge clk);
    cmd_op = 2'b01; cmd_bit = 1'b0; cmd_valid = 1'b1;
    repeat (12) @(negedge clk);
    chk(busy == 0 && scl_oe == 0, "R2 no start on busy bus", busy, 0);
    chk(cmd_ready == 0, "R2 ready low on busy bus", cmd_ready, 0);
    cmd_valid = 1'b0;
    oth_sda = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R5 R7 send a zero from a free bus
    r0 = rises;
    do_cmd(2'b01, 1'b0);
    chk(rises - r0 == 1, "R3 one clock pulse", rises - r0, 1);
    chk(sda_at_rise == 0, "R3 sent zero on line", sda_at_rise, 0);
    chk(last_low >= HALF && last_low <= HALF + 4, "R5 low phase length", last_low, HALF);
    chk(last_high >= HALF && last_high <= HALF + 5, "R7 high phase length", last_high, HALF);
    chk(got_lost == 0, "R9 no loss on zero", got_lost, 0);
    chk(scl_oe == 1, "R7 engine holds clock low after bit", scl_oe, 1);

    // R3 send a one while holding the bus
    r0 = rises;
    do_cmd(2'b01, 1'b1);
    chk(rises - r0 == 1, "R3 one clock pulse second bit", rises - r0, 1);
    chk(sda_at_rise == 1, "R3 sent one on line", sda_at_rise, 1);
    chk(got_bit == 1 && got_lost == 0, "R9 one read back high", got_bit, 1);

    // R8 receive: slave drives zero then releases for a one
    fork
      begin oth_sda = 1'b1; end
    join
    do_cmd(2'b10, 1'b0);
    chk(got_bit == 0, "R8 received zero", got_bit, 0);
    chk(sda_oe == 0, "R8 engine does not drive on receive", sda_oe, 0);
    oth_sda = 1'b0;
    do_cmd(2'b10, 1'b0);
    chk(got_bit == 1, "R8 received one", got_bit, 1);

    // R6 slave stretches the clock for 40 cycles after release
    fork
      begin
        @(negedge clk); oth_scl = 1'b1;
        repeat (40 + HALF) @(negedge clk);
        oth_scl = 1'b0;
      end
      do_cmd(2'b01, 1'b0);
    join
    chk(last_low >= 40 + HALF, "R6 waited out stretch", last_low, 40 + HALF);
    chk(last_high >= HALF, "R6 full high after stretch", last_high, HALF);

    // R7 another master pulls the clock low early in the high phase
    fork
      begin
        @(posedge scl_line);
        repeat (3) @(negedge clk);
        oth_scl = 1'b1;
        t0 = cyc;
        repeat (20) @(negedge clk);
        oth_scl = 1'b0;
      end
      do_cmd(2'b01, 1'b0);
    join
    chk(last_high < HALF, "R7 high cut short", last_high, 3);
    chk(pull_cyc - t0 <= 4 && pull_cyc >= t0, "R7 engine re-pulls clock", pull_cyc - t0, 3);

    // R9 arbitration loss: send one while another master sends zero
    fork
      begin
        @(posedge busy); oth_sda = 1'b1;
      end
      begin
        do_cmd(2'b01, 1'b1);
      end
    join
    chk(got_lost == 1, "R9 loss reported", got_lost, 1);
    chk(scl_oe == 0 && sda_oe == 0, "R9 lines released", {scl_oe, sda_oe}, 0);
    chk(last_high >= HALF || high_len >= HALF, "R9 busy to slot end", high_len, HALF);
    repeat (4) @(negedge clk);
    chk(cmd_ready == 0, "R9 bus no longer owned", cmd_ready, 0);
    oth_sda = 1'b0;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1, "R2 ready once bus free", cmd_ready, 1);

    // R10 take the bus again then release it
    do_cmd(2'b01, 1'b0);
    chk(scl_oe == 1 && sda_oe == 1, "R10 bus held before release", {scl_oe, sda_oe}, 3);
    do_cmd(2'b00, 1'b0);
    chk(scl_oe == 0 && sda_oe == 0, "R10 release frees lines", {scl_oe, sda_oe}, 0);
    chk(got_lost == 0, "R10 no loss on release", got_lost, 0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule